// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one fast clock and produces two slower clocks from it. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of it. Both dividers advance on the same rising input edges from a single advance decision, so edges they have in common fall on the same input edge.

An active-high `halt` input freezes both dividers. It is captured on the falling input edge, and outputs change only on rising edges, so halting and resuming never shortens a pulse. An asynchronous active-high master reset clears everything, so several instances released from reset together stay in phase. A new ratio select takes effect only when the divider wraps, so the period in progress always finishes at its old length.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While `mrst` is high, `out_a` and `out_b` are 0. Assertion of `mrst` clears them at once, without waiting for a clock edge.
- R2: With `sel_a` = 0, `out_a` has a period of 2 input cycles: 1 cycle high and 1 cycle low. With `sel_a` = 1, the period is 4 cycles: 2 high and 2 low.
- R3: `sel_b` encoding: 00 gives a period of 4 (2 high, 2 low), 01 gives a period of 6 (3 high, 3 low), and 10 or 11 give a period of 5 (3 high, 2 low).
- R4: A rising edge of `clk_in` advances the dividers only if `halt` was low at the preceding falling edge of `clk_in`. After a reset release, no edge advances the dividers until a falling edge has sampled `halt`.
- R5: A rising edge that does not advance leaves `out_a`, `out_b` and the internal divider phase unchanged.
- R6: A select change takes effect at the first advancing edge that starts a new period of that output. The period in progress completes at the old ratio.
- R7: The two dividers advance together. After reset release, the first advancing edge drives both outputs high, and each output starts its periods with a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| halt | input | 1 | Freeze request, sampled on the falling edge of clk_in |
| sel_a | input | 1 | Ratio select for output A (0: /2, 1: /4) |
| sel_b | input | 2 | Ratio select for output B (00: /4, 01: /6, 1x: /5) |
| out_a | output | 1 | Divided clock A, registered |
| out_b | output | 1 | Divided clock B, registered |

## Verification
The assertions take three things for granted. `halt` is stable around the falling edge. `sel_a` and `sel_b` are stable around the rising edge. `mrst` is released away from a rising edge. The stimulus keeps to this by changing `halt` and both selects one time unit after a rising edge, and by asserting and releasing `mrst` between edges. Select changes are applied in the middle of a period as well as at a period boundary, and `halt` is driven both as long runs and as a change on every cycle. The outputs are compared every cycle against a behavioural model that tracks each output by its phase within the period.

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
  parameter int A_LO = 2,
  parameter int A_HI = 4,
  parameter int B_00 = 4,
  parameter int B_01 = 6,
  parameter int B_1X = 5,
  localparam int MAX_A = (A_LO > A_HI) ? A_LO : A_HI,
  localparam int MAX_B = (B_00 > B_01) ? ((B_00 > B_1X) ? B_00 : B_1X)
                                       : ((B_01 > B_1X) ? B_01 : B_1X),
  localparam int MAX_R = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CW = $clog2(MAX_R + 1)
) (
  input  logic       clk_in,
  input  logic       mrst,
  input  logic       halt,
  input  logic       sel_a,
  input  logic [1:0] sel_b,
  output logic       out_a,
  output logic       out_b
);

  logic          run_q;
  logic [CW-1:0] cnt_a, cnt_b, rat_a, rat_b;
  logic [CW-1:0] pick_a, pick_b, nxt_a, nxt_b, nrat_a, nrat_b;
  logic          wrap_a, wrap_b;

  // halt captured on the falling edge: the next rising edge sees a settled value
  always_ff @(negedge clk_in or posedge mrst)
    if (mrst) run_q <= 1'b0;
    else      run_q <= ~halt;

  assign pick_a = sel_a ? CW'(A_HI) : CW'(A_LO);
  assign pick_b = sel_b[1] ? CW'(B_1X) : (sel_b[0] ? CW'(B_01) : CW'(B_00));

  assign wrap_a = (cnt_a == '0) || (cnt_a == rat_a);
  assign wrap_b = (cnt_b == '0) || (cnt_b == rat_b);
  assign nxt_a  = wrap_a ? CW'(1) : cnt_a + CW'(1);
  assign nxt_b  = wrap_b ? CW'(1) : cnt_b + CW'(1);
  assign nrat_a = wrap_a ? pick_a : rat_a;
  assign nrat_b = wrap_b ? pick_b : rat_b;

  // phase 1..ceil(N/2) is high, the rest low
  always_ff @(posedge clk_in or posedge mrst)
    if (mrst) begin
      cnt_a <= '0;
      cnt_b <= '0;
      rat_a <= '0;
      rat_b <= '0;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (run_q) begin
      cnt_a <= nxt_a;
      cnt_b <= nxt_b;
      rat_a <= nrat_a;
      rat_b <= nrat_b;
      out_a <= ({1'b0, nxt_a} <= (({1'b0, nrat_a} + 1'b1) >> 1));
      out_b <= ({1'b0, nxt_b} <= (({1'b0, nrat_b} + 1'b1) >> 1));
    end

endmodule

module dual_ratio_clkdiv_chk #(
  parameter int CW = 3
) (
  input logic          clk_in,
  input logic          mrst,
  input logic          run_q,
  input logic          out_a,
  input logic          out_b,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] rat_a,
  input logic [CW-1:0] rat_b
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_in)
    mrst |-> (!out_a && !out_b && cnt_a == '0 && cnt_b == '0));

  // R5
  hold_freeze_chk: assert property (@(posedge clk_in) disable iff (mrst)
    !run_q |=> ($stable(out_a) && $stable(out_b) && $stable(cnt_a) && $stable(cnt_b)));

  // R6
  a_ratio_at_wrap_chk: assert property (@(posedge clk_in) disable iff (mrst)
    !$stable(rat_a) |-> (cnt_a == CW'(1)));

  // R6
  b_ratio_at_wrap_chk: assert property (@(posedge clk_in) disable iff (mrst)
    !$stable(rat_b) |-> (cnt_b == CW'(1)));

  // R7
  lockstep_chk: assert property (@(posedge clk_in) disable iff (mrst)
    (cnt_a == '0) == (cnt_b == '0));

  // R2
  a_high_window_chk: assert property (@(posedge clk_in) disable iff (mrst)
    out_a |-> ((cnt_a <= rat_a) && ((2 * cnt_a) <= (rat_a + 1))));

  // R3
  b_high_window_chk: assert property (@(posedge clk_in) disable iff (mrst)
    out_b |-> ((cnt_b <= rat_b) && ((2 * cnt_b) <= (rat_b + 1))));

endmodule

bind dual_ratio_clkdiv dual_ratio_clkdiv_chk #(.CW(CW)) u_chk (
  .clk_in(clk_in), .mrst(mrst), .run_q(run_q), .out_a(out_a), .out_b(out_b),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .rat_a(rat_a), .rat_b(rat_b)
);

// File: tb/tb_dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_ratio_clkdiv;
  logic clk_in = 1'b0;
  logic mrst = 1'b1;
  logic halt = 1'b0;
  logic sel_a = 1'b0;
  logic [1:0] sel_b = 2'b00;
  logic out_a, out_b;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state
  int pa = 0, pb = 0, na = 0, nb = 0;
  bit ea = 0, eb = 0, run_m = 0;
  // period tracking on out_b
  bit measure = 0;
  int since_rise = -1;
  int high_len = 0;
  int exp_per = 0;
  bit prev_b = 0;

  dual_ratio_clkdiv dut (
    .clk_in(clk_in), .mrst(mrst), .halt(halt), .sel_a(sel_a), .sel_b(sel_b),
    .out_a(out_a), .out_b(out_b)
  );

  always #10 clk_in = ~clk_in;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int ratio_b(bit [1:0] s);
    return s[1] ? 5 : (s[0] ? 6 : 4);
  endfunction

  task automatic model_reset();
    pa = 0; pb = 0; na = 0; nb = 0; ea = 0; eb = 0; run_m = 0;
    since_rise = -1; prev_b = 0;
  endtask

  task automatic model_advance(bit sa, bit [1:0] sb);
    if (pa == 0 || pa == na) begin na = sa ? 4 : 2; pa = 1; end else pa++;
    if (pb == 0 || pb == nb) begin nb = ratio_b(sb); pb = 1; end else pb++;
    ea = (2 * pa <= na + 1);
    eb = (2 * pb <= nb + 1);
  endtask

  // drive just after a rising edge, sample halt at the falling edge, compare after the rising edge
  task automatic step(bit h, bit sa, bit [1:0] sb);
    halt = h; sel_a = sa; sel_b = sb;
    @(negedge clk_in);
    run_m = mrst ? 1'b0 : !halt;
    @(posedge clk_in);
    if (!mrst && run_m) model_advance(sa, sb);
    #1;
    check(cur_req, "out_a", out_a, ea);
    check(cur_req, "out_b", out_b, eb);
    if (measure) begin
      if (since_rise >= 0) since_rise++;
      if (out_b) high_len++;
      if (out_b && !prev_b) begin
        if (since_rise > 0) check("R3", "out_b period", since_rise, exp_per);
        since_rise = 0;
        high_len = 1;
      end
      if (!out_b && prev_b && since_rise > 0)
        check("R3", "out_b high cycles", high_len, (exp_per + 1) / 2);
      prev_b = out_b;
    end
  endtask

  task automatic run(int n, bit h, bit sa, bit [1:0] sb);
    for (int i = 0; i < n; i++) step(h, sa, sb);
  endtask

  task automatic measure_b(bit [1:0] sb);
    exp_per = ratio_b(sb);
    run(8, 1'b0, 1'b0, sb);
    measure = 1; since_rise = -1; prev_b = out_b; high_len = 0;
    run(3 * exp_per + 2, 1'b0, 1'b0, sb);
    measure = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    model_reset();
    run(3, 1'b0, 1'b0, 2'b00);
    // release between edges
    #4 mrst = 0;
    // R7: first advancing edge raises both outputs
    step(1'b0, 1'b0, 2'b00);
    check("R7", "out_a first edge", out_a, 1);
    check("R7", "out_b first edge", out_b, 1);
    // R2, R3: /2 and /4
    cur_req = "R2";
    run(16, 1'b0, 1'b0, 2'b00);
    // R6: select change in the middle of a period
    cur_req = "R6";
    run(2, 1'b0, 1'b1, 2'b01);
    run(22, 1'b0, 1'b1, 2'b01);
    cur_req = "R3";
    run(20, 1'b0, 1'b1, 2'b10);
    run(20, 1'b0, 1'b0, 2'b11);
    // R5: long hold, started inside a high phase
    cur_req = "R5";
    run(1, 1'b0, 1'b1, 2'b01);
    run(7, 1'b1, 1'b1, 2'b01);
    // R5: selects changed while held must not act
    run(4, 1'b1, 1'b0, 2'b10);
    // R4: resume, then halt toggling every cycle
    cur_req = "R4";
    run(9, 1'b0, 1'b0, 2'b10);
    for (int i = 0; i < 24; i++) step(i[0], 1'b1, 2'b00);
    for (int i = 0; i < 18; i++) step((i % 3) == 0, 1'b0, 2'b01);
    // R3: explicit periods and high widths for every B select
    measure_b(2'b00);
    measure_b(2'b01);
    measure_b(2'b10);
    measure_b(2'b11);
    // R1: asynchronous reset between edges
    cur_req = "R1";
    run(3, 1'b0, 1'b1, 2'b01);
    #5 mrst = 1;
    #1;
    check("R1", "out_a async clear", out_a, 0);
    check("R1", "out_b async clear", out_b, 0);
    model_reset();
    @(posedge clk_in); #1;
    run(2, 1'b0, 1'b1, 2'b01);
    // R4: release with halt high, nothing advances until halt drops
    #4 mrst = 0;
    cur_req = "R4";
    run(3, 1'b1, 1'b1, 2'b01);
    cur_req = "R7";
    step(1'b0, 1'b1, 2'b01);
    check("R7", "out_a after held release", out_a, 1);
    check("R7", "out_b after held release", out_b, 1);
    run(30, 1'b0, 1'b1, 2'b01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule